// File: doc/BRIEF.md
# Paged Effective Address Generator

This block forms the operand address for the memory-reference instructions of a 12-bit machine with a 4096-word memory split into 32 pages of 128 words. It takes an instruction word and the page number of the location the instruction was fetched from. From these it builds a 12-bit address. The 7-bit in-page offset is joined either to the instruction's own page or to page zero.

When the instruction asks for indirection, the block reads the formed address through a simple request/acknowledge memory port. The word that comes back is the effective address. A small fixed window of page-zero locations acts as auto-index pointers. When one of them is used indirectly, the block increments the pointer, writes it back, and uses the incremented value. The result is presented on a 12-bit output together with a one-cycle done strobe. The surrounding sequencer then either fetches the operand from that address or, for a jump, loads it as the new program counter.

Top module: `paged_ea_gen`

## Requirements
- R1: After reset `done` and `memReq` are low and `effAddr` is zero.
- R2: The opcode sits in `instr[11:9]`. Values 0 to 5 are memory references. A `start` with opcode 6 or 7 is ignored: no `done`, and no memory request follows.
- R3: When the page-select bit `instr[7]` is 0, the formed address is `{5'b0, instr[6:0]}`, which lies in page zero.
- R4: When `instr[7]` is 1, the formed address is `{instrPage, instr[6:0]}`. Here `instrPage` is the page that holds the instruction.
- R5: When the indirect bit `instr[8]` is 0, `effAddr` equals the formed address and `done` pulses in the cycle after `start`, with no memory request.
- R6: When `instr[8]` is 1, the block raises `memReq` with `memWe` low at the formed address. It holds the request and the address stable until `memAck`. In the cycle after the acknowledge, `effAddr` carries `memRdata` and `done` pulses.
- R7: An indirect reference whose formed address lies in octal 0010 to 0017 (decimal 8 to 15) is followed by a write request (`memWe` high) to the same address. The data is the read word plus one, modulo 4096. `done` pulses in the cycle after the write acknowledge, with `effAddr` equal to the incremented value.
- R8: A direct reference to octal 0010 to 0017 makes no memory access and leaves the pointer unchanged.
- R9: A jump (opcode 5) forms its address like any other memory reference. The block issues no access to the final address: an indirect jump makes exactly one read and no write.
- R10: A `start` that arrives while an indirect reference is in progress is ignored. Only the first reference produces `done`.
- R11: `done` is high for exactly one cycle per accepted reference.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin address generation for `instr` |
| instr | input | 12 | Instruction word |
| instrPage | input | 5 | Page of the instruction's own location |
| memReq | output | 1 | Memory request, held until acknowledged |
| memWe | output | 1 | Request is a write |
| memAddr | output | 12 | Memory request address |
| memWdata | output | 12 | Write data (incremented pointer) |
| memAck | input | 1 | Memory acknowledge |
| memRdata | input | 12 | Read data, valid with `memAck` |
| effAddr | output | 12 | Effective address, valid with `done` |
| done | output | 1 | One-cycle completion strobe |

## Verification
Direct references are tried with the page-select bit both clear and set, and with a top-of-memory offset and page, so that a swapped or dropped page field shows up in the address. Indirect references are tried through ordinary locations and through the auto-index window, with acknowledge latencies of zero and several cycles. This separates a plain pointer read from read-increment-write, and a correct wait from early completion. A pointer holding 7777 octal exposes a missing modulo wrap. Direct access to a window location, an indirect jump, opcodes 6 and 7, and a start issued while busy tell whether the block makes accesses or completions it should not.

// File: rtl/paged_ea_pkg.sv
package paged_ea_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READ  = 2'd1,
    ST_WRITE = 2'd2
  } eaState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;     // latch formed address as pointer address
    logic takeDirect;  // effective address = formed address
    logic takeRead;    // effective address = read word
    logic takeInc;     // write-back word = read word + 1
    logic takeWrite;   // effective address = write-back word
  } eaStrobe_t;

endpackage

// File: rtl/ea_datapath.sv
module ea_datapath
  import paged_ea_pkg::*;
#(
  parameter int ADDR_W     = 12,
  parameter int OFF_W      = 7,
  parameter int OP_W       = 3,
  parameter int MEMREF_OPS = 6,
  parameter int AUTO_BASE  = 8,
  parameter int AUTO_COUNT = 8
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  eaStrobe_t               strobe,
  input  logic [ADDR_W-1:0]       instr,
  input  logic [ADDR_W-OFF_W-1:0] instrPage,
  input  logic [ADDR_W-1:0]       memRdata,
  output logic                    isMemRef,
  output logic                    indirect,
  output logic                    isAuto,
  output logic [ADDR_W-1:0]       memAddr,
  output logic [ADDR_W-1:0]       memWdata,
  output logic [ADDR_W-1:0]       effAddr
);
  localparam int PAGE_W = ADDR_W - OFF_W;
  localparam int IND_BIT = ADDR_W - OP_W - 1;
  localparam int PSEL_BIT = ADDR_W - OP_W - 2;
  localparam logic [OP_W-1:0] MEMREF_TOP = OP_W'(MEMREF_OPS - 1);
  localparam logic [ADDR_W-1:0] AUTO_LO = ADDR_W'(AUTO_BASE);
  localparam logic [ADDR_W-1:0] AUTO_HI = ADDR_W'(AUTO_BASE + AUTO_COUNT - 1);

  logic [OP_W-1:0]   opcode;
  logic [PAGE_W-1:0] pageSel;
  logic [ADDR_W-1:0] formed;
  logic [ADDR_W-1:0] ptrAddr;
  logic [ADDR_W-1:0] wbData;
  logic [ADDR_W-1:0] effReg;

  always_comb begin
    opcode   = instr[ADDR_W-1 -: OP_W];
    isMemRef = (opcode <= MEMREF_TOP);
    indirect = instr[IND_BIT];
    pageSel  = instr[PSEL_BIT] ? instrPage : '0;
    formed   = {pageSel, instr[OFF_W-1:0]};
    isAuto   = (ptrAddr >= AUTO_LO) && (ptrAddr <= AUTO_HI);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ptrAddr <= '0;
      wbData  <= '0;
      effReg  <= '0;
    end else begin
      if (strobe.capture)    ptrAddr <= formed;
      if (strobe.takeDirect) effReg  <= formed;
      if (strobe.takeRead)   effReg  <= memRdata;
      if (strobe.takeInc)    wbData  <= memRdata + 1'b1;
      if (strobe.takeWrite)  effReg  <= wbData;
    end
  end

  assign memAddr  = ptrAddr;
  assign memWdata = wbData;
  assign effAddr  = effReg;

endmodule

// File: rtl/ea_control.sv
module ea_control
  import paged_ea_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      start,
  input  logic      isMemRef,
  input  logic      indirect,
  input  logic      isAuto,
  input  logic      memAck,
  output eaStrobe_t strobe,
  output logic      memReq,
  output logic      memWe,
  output logic      done
);
  eaState_t state, nextState;

  always_comb begin
    strobe    = '0;
    nextState = state;
    unique case (state)
      ST_IDLE: begin
        if (start && isMemRef) begin
          strobe.capture = 1'b1;
          if (indirect) nextState = ST_READ;
          else          strobe.takeDirect = 1'b1;
        end
      end
      ST_READ: begin
        if (memAck) begin
          if (isAuto) begin
            strobe.takeInc = 1'b1;
            nextState      = ST_WRITE;
          end else begin
            strobe.takeRead = 1'b1;
            nextState       = ST_IDLE;
          end
        end
      end
      ST_WRITE: begin
        if (memAck) begin
          strobe.takeWrite = 1'b1;
          nextState        = ST_IDLE;
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      done  <= 1'b0;
    end else begin
      state <= nextState;
      done  <= strobe.takeDirect | strobe.takeRead | strobe.takeWrite;
    end
  end

  assign memReq = (state != ST_IDLE);
  assign memWe  = (state == ST_WRITE);

endmodule

// File: rtl/paged_ea_gen.sv
module paged_ea_gen
  import paged_ea_pkg::*;
#(
  parameter int ADDR_W     = 12,
  parameter int OFF_W      = 7,
  parameter int OP_W       = 3,
  parameter int MEMREF_OPS = 6,
  parameter int AUTO_BASE  = 8,
  parameter int AUTO_COUNT = 8
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    start,
  input  logic [ADDR_W-1:0]       instr,
  input  logic [ADDR_W-OFF_W-1:0] instrPage,
  output logic                    memReq,
  output logic                    memWe,
  output logic [ADDR_W-1:0]       memAddr,
  output logic [ADDR_W-1:0]       memWdata,
  input  logic                    memAck,
  input  logic [ADDR_W-1:0]       memRdata,
  output logic [ADDR_W-1:0]       effAddr,
  output logic                    done
);
  eaStrobe_t strobe;
  logic isMemRef, indirect, isAuto;

  ea_control u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .isMemRef(isMemRef),
    .indirect(indirect), .isAuto(isAuto), .memAck(memAck),
    .strobe(strobe), .memReq(memReq), .memWe(memWe), .done(done)
  );

  ea_datapath #(
    .ADDR_W(ADDR_W), .OFF_W(OFF_W), .OP_W(OP_W), .MEMREF_OPS(MEMREF_OPS),
    .AUTO_BASE(AUTO_BASE), .AUTO_COUNT(AUTO_COUNT)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .instr(instr),
    .instrPage(instrPage), .memRdata(memRdata), .isMemRef(isMemRef),
    .indirect(indirect), .isAuto(isAuto), .memAddr(memAddr),
    .memWdata(memWdata), .effAddr(effAddr)
  );

endmodule

// File: rtl/paged_ea_checker.sv
module paged_ea_checker #(
  parameter int ADDR_W     = 12,
  parameter int OP_W       = 3,
  parameter int MEMREF_OPS = 6,
  parameter int AUTO_BASE  = 8,
  parameter int AUTO_COUNT = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              start,
  input logic [ADDR_W-1:0] instr,
  input logic              memReq,
  input logic              memWe,
  input logic [ADDR_W-1:0] memAddr,
  input logic [ADDR_W-1:0] memWdata,
  input logic              memAck,
  input logic [ADDR_W-1:0] memRdata,
  input logic [ADDR_W-1:0] effAddr,
  input logic              done
);
  localparam int IND_BIT = ADDR_W - OP_W - 1;
  localparam logic [OP_W-1:0] MEMREF_TOP = OP_W'(MEMREF_OPS - 1);
  localparam logic [ADDR_W-1:0] AUTO_LO = ADDR_W'(AUTO_BASE);
  localparam logic [ADDR_W-1:0] AUTO_HI = ADDR_W'(AUTO_BASE + AUTO_COUNT - 1);

  logic inWindow;
  logic isRef;
  assign inWindow = (memAddr >= AUTO_LO) && (memAddr <= AUTO_HI);
  assign isRef    = instr[ADDR_W-1 -: OP_W] <= MEMREF_TOP;

  // R2
  ignore_op_chk: assert property (@(posedge clk) disable iff (!rstN)
    start && !memReq && !isRef |=> !done && !memReq);

  // R5
  direct_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    start && !memReq && isRef && !instr[IND_BIT] |=> done && !memReq);

  // R6
  held_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !memAck |=> memReq && $stable(memAddr) && $stable(memWe));

  // R6
  read_result_chk: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !memWe && memAck && !inWindow |=> done && effAddr == $past(memRdata));

  // R7
  wb_window_chk: assert property (@(posedge clk) disable iff (!rstN)
    memWe |-> memReq && inWindow);

  // R7
  wb_result_chk: assert property (@(posedge clk) disable iff (!rstN)
    memReq && memWe && memAck |=> done && effAddr == $past(memWdata));

  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R6
  no_done_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> !done);

endmodule

bind paged_ea_gen paged_ea_checker #(
  .ADDR_W(ADDR_W), .OP_W(OP_W), .MEMREF_OPS(MEMREF_OPS),
  .AUTO_BASE(AUTO_BASE), .AUTO_COUNT(AUTO_COUNT)
) u_checker (
  .clk(clk), .rstN(rstN), .start(start), .instr(instr), .memReq(memReq),
  .memWe(memWe), .memAddr(memAddr), .memWdata(memWdata), .memAck(memAck),
  .memRdata(memRdata), .effAddr(effAddr), .done(done)
);

// File: tb/paged_ea_gen_tb.sv
module paged_ea_gen_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [11:0] instr = '0;
  logic [4:0]  instrPage = '0;
  logic        memReq, memWe, memAck, done;
  logic [11:0] memAddr, memWdata, memRdata, effAddr;

  logic [11:0] mem [4096];
  int latency = 0;
  int waitCnt = 0;
  int rdCnt = 0;
  int wrCnt = 0;
  int checks = 0;
  int fails = 0;
  bit finished = 0;
  logic [11:0] expQ [$];

  always #(CLK_PERIOD/2) clk = ~clk;

  paged_ea_gen u_dut (
    .clk(clk), .rstN(rstN), .start(start), .instr(instr),
    .instrPage(instrPage), .memReq(memReq), .memWe(memWe),
    .memAddr(memAddr), .memWdata(memWdata), .memAck(memAck),
    .memRdata(memRdata), .effAddr(effAddr), .done(done)
  );

  // memory model
  assign memAck   = memReq && (waitCnt >= latency);
  assign memRdata = mem[memAddr];
  always @(posedge clk) begin
    if (!memReq || memAck) waitCnt <= 0;
    else waitCnt <= waitCnt + 1;
    if (memReq && memAck) begin
      if (memWe) begin
        mem[memAddr] <= memWdata;
        wrCnt <= wrCnt + 1;
      end else rdCnt <= rdCnt + 1;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%o expected=%o", tag, act, exp);
    end
  endtask

  // monitor: compares each completion with the scoreboard queue
  always @(negedge clk) begin
    if (rstN && done) begin
      if (expQ.size() == 0) check(0, "R10/R2 unexpected done", int'(effAddr), 0);
      else begin
        logic [11:0] e;
        e = expQ.pop_front();
        check(effAddr == e, "R3/R4/R6/R7 effAddr", int'(effAddr), int'(e));
      end
    end
  end

  // driver: compute expectation, push it, run the reference
  task automatic run(input logic [11:0] ins, input logic [4:0] pg, input int lat,
                     input string tag);
    logic [11:0] formed, exp, wbExp;
    bit ind, auto;
    int r0, w0, n, expR, expW;
    formed = ins[7] ? {pg, ins[6:0]} : {5'b0, ins[6:0]};
    ind = ins[8];
    auto = ind && formed >= 12'd8 && formed <= 12'd15;
    exp = ind ? mem[formed] : formed;
    if (auto) exp = exp + 12'd1;
    wbExp = auto ? exp : mem[formed];
    expR = ind ? 1 : 0;
    expW = auto ? 1 : 0;
    latency = lat;
    r0 = rdCnt; w0 = wrCnt;
    expQ.push_back(exp);
    instr = ins; instrPage = pg; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    n = 1;
    if (!ind) check(done == 1'b1, {tag, " R5 done one cycle after start"}, int'(done), 1);
    while (!done && n < 60) begin
      @(negedge clk);
      n++;
    end
    @(negedge clk);
    check(done == 1'b0, {tag, " R11 done single pulse"}, int'(done), 0);
    check(rdCnt - r0 == expR, {tag, " R5/R8/R9 read count"}, rdCnt - r0, expR);
    check(wrCnt - w0 == expW, {tag, " R7/R8/R9 write count"}, wrCnt - w0, expW);
    check(mem[formed] == wbExp, {tag, " R7/R8 pointer in memory"}, int'(mem[formed]), int'(wbExp));
  endtask

  task automatic ignored(input logic [11:0] ins, input string tag);
    int r0;
    r0 = rdCnt;
    instr = ins; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(done == 1'b0 && memReq == 1'b0, {tag, " R2 opcode ignored"}, int'({done, memReq}), 0);
    repeat (4) @(negedge clk);
    check(rdCnt == r0, {tag, " R2 no access"}, rdCnt - r0, 0);
  endtask

  initial begin
    for (int i = 0; i < 4096; i++) mem[i] = 12'((i * 37 + 5) & 12'hFFF);
    mem[8]  = 12'o1234;
    mem[15] = 12'o7777;
    mem[32] = 12'o4567;
    mem[10] = 12'o0200;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1
    check(done == 0 && memReq == 0 && effAddr == 0, "R1 reset state", int'({done, memReq, effAddr}), 0);

    // R3: page zero, direct
    run({3'd1, 1'b0, 1'b0, 7'o025}, 5'd3, 0, "R3 page zero");
    // R4: current page, top of memory
    run({3'd2, 1'b0, 1'b1, 7'o177}, 5'h1F, 0, "R4 current page");
    run({3'd3, 1'b0, 1'b1, 7'o003}, 5'h0A, 0, "R4 mid page");
    // R8: direct to auto-index slot, no increment
    run({3'd0, 1'b0, 1'b0, 7'o012}, 5'd7, 0, "R8 direct window");
    // R6: indirect, zero and longer latency
    run({3'd0, 1'b1, 1'b0, 7'o040}, 5'd9, 0, "R6 indirect lat0");
    run({3'd4, 1'b1, 1'b1, 7'o100}, 5'd2, 3, "R6 indirect lat3");
    // R9: jump indirect
    run({3'd5, 1'b1, 1'b1, 7'o022}, 5'd6, 1, "R9 jump indirect");
    run({3'd5, 1'b0, 1'b1, 7'o022}, 5'd6, 0, "R9 jump direct");
    // R7: auto-index, including wrap
    run({3'd1, 1'b1, 1'b0, 7'o010}, 5'd4, 2, "R7 autoinc");
    run({3'd1, 1'b1, 1'b0, 7'o010}, 5'd4, 0, "R7 autoinc again");
    run({3'd2, 1'b1, 1'b0, 7'o017}, 5'd1, 1, "R7 autoinc wrap");
    // window edge: 0020 is not auto
    run({3'd2, 1'b1, 1'b0, 7'o020}, 5'd1, 0, "R7 outside window");
    // R2: opcodes 6 and 7
    ignored({3'd6, 1'b1, 1'b0, 7'o010}, "R2 op6");
    ignored({3'd7, 1'b0, 1'b1, 7'o055}, "R2 op7");

    // R10: start during a busy indirect reference
    begin
      latency = 5;
      expQ.push_back(mem[32]);
      instr = {3'd0, 1'b1, 1'b0, 7'o040}; instrPage = 5'd0; start = 1'b1;
      @(negedge clk);
      instr = {3'd1, 1'b0, 1'b0, 7'o077};
      repeat (3) @(negedge clk);
      start = 1'b0;
      repeat (10) @(negedge clk);
      check(expQ.size() == 0, "R10 busy start ignored, queue drained", expQ.size(), 0);
    end

    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=hung expected=finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule